// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a display timing generator and the pins of a parallel RGB panel. Each pixel-clock cycle it takes a 24-bit pixel and active-high horizontal sync, vertical sync and data-enable strobes. It reorders the three colour channels and packs them onto 24 data pins in one of several padded layouts. Each strobe then gets its own polarity, launch edge and disable setting. The block also forwards the pixel clock, with optional inversion, as a pin.

All configuration lives in one 17-bit control word, written through a small synchronous register port. Every address other than the control address reads back a constant identifier, so software can detect the block. A write takes effect at once while the block is disabled. While the block is enabled, a write is held and only applied at the next vertical sync boundary, so a frame is never half in one format and half in another. When the block is switched on, the output datapath is cleared for one cycle before live pixels flow.

Top module: `rgb_par_fmt`

## Requirements
- R1: While reset is asserted, every output pin is 0 and the control address reads 0.
- R2: A read of any address other than 0 returns 0x00647069. A read of address 0 returns the last written control value in bits 16:0, with bits 31:17 reading 0. Reads are combinational on the address.
- R3: Control bits 15:14 choose the channel order as slots (A,B,C), where the input pixel is R=[23:16], G=[15:8], B=[7:0]. Code 0 gives (R,G,B), 1 gives (B,G,R), 2 gives (G,R,B) and 3 gives (B,R,G).
- R4: Control bits 13:11 choose the packing of the slots, MSB first. Code 0 gives all zero. Code 1 gives 8 zeros, A[7:3], B[7:2], C[7:3]. Code 2 gives 000,A[7:3],00,B[7:2],000,C[7:3]. Code 3 gives 00,A[7:3],000,B[7:2],00,C[7:3],0. Code 4 gives 6 zeros, A[7:2], B[7:2], C[7:2]. Code 5 gives 00,A[7:2],00,B[7:2],00,C[7:2]. Code 6 gives A,B,C. Code 7 gives all zero.
- R5: Bit 10 inverts the pixel clock pin. Bits 9, 8 and 7 invert the hsync, vsync and enable pins.
- R6: Inputs are sampled on the rising clock edge. With launch bits 6 (hsync), 5 (vsync) and 4 (enable) clear, the pin changes just after that rising edge. With the bit set, the pin changes at the following falling edge. The data pins follow the enable pin's launch bit.
- R7: Bits 3, 2 and 1 disable hsync, vsync and enable. A disabled pin stays at its inactive level, which equals its inversion bit.
- R8: Bit 0 is the enable. While it is 0, the data pins are 0, the pixel clock pin is 0 and each strobe pin sits at its inactive level. In the first cycle after the enable takes effect, the outputs are still idle, and live data follows one cycle later.
- R9: With bit 16 set, the enable pin carries a composite sync, (hsync OR vsync) XOR bit 7, in place of the data enable.
- R10: While the block is enabled, a control write takes effect at the next clock edge where vs_i is high after being low on the previous edge. While the block is disabled, a write takes effect at its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pix_i | input | 24 | Input pixel, red in the top byte |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high |
| de_i | input | 1 | Data enable, active high |
| out_pclk | output | 1 | Pixel clock pin |
| out_hs | output | 1 | Horizontal sync pin |
| out_vs | output | 1 | Vertical sync pin |
| out_de | output | 1 | Enable or composite sync pin |
| out_data | output | 24 | Packed data pins |

## Verification
The assertions take the strobes and the register port as synchronous to the rising clock edge, with values that settle well before that edge. They also assume the configuration seen at one edge is the one the following pin values were built from. The stimulus changes inputs only between the falling edge and the next rising edge. It samples the pins a quarter cycle after each edge. Before any reconfiguration, vs_i is driven low for a clean rising boundary, and after reconfiguration the bench waits for the enable-reset cycle to pass before it compares live pixels.

// File: rtl/rgb_fmt_pkg.sv
package rgb_fmt_pkg;

   localparam int CTRL_W = 17;

   typedef struct packed {
      logic       csync;
      logic [1:0] order;
      logic [2:0] pack;
      logic       inv_pclk;
      logic       inv_hs;
      logic       inv_vs;
      logic       inv_de;
      logic       neg_hs;
      logic       neg_vs;
      logic       neg_de;
      logic       dis_hs;
      logic       dis_vs;
      logic       dis_de;
      logic       en;
   } fmt_ctrl_t;

   typedef enum logic [1:0] {
      ORD_RGB = 2'd0,
      ORD_BGR = 2'd1,
      ORD_GRB = 2'd2,
      ORD_BRG = 2'd3
   } ord_e;

   typedef enum logic [2:0] {
      PK_ZERO     = 3'd0,
      PK_565_LO   = 3'd1,
      PK_565_LANE = 3'd2,
      PK_565_MID  = 3'd3,
      PK_666_LO   = 3'd4,
      PK_666_LANE = 3'd5,
      PK_888      = 3'd6,
      PK_RSVD     = 3'd7
   } pack_e;

   localparam int SIG_HS = 0;
   localparam int SIG_VS = 1;
   localparam int SIG_DE = 2;
   localparam int NSIG   = 3;

endpackage

// File: rtl/rgb_fmt_regs.sv
module rgb_fmt_regs
   import rgb_fmt_pkg::*;
#(
   parameter int          ADDR_W    = 4,
   parameter int          DATA_W    = 32,
   parameter int          CTRL_ADDR = 0,
   parameter logic [31:0] ID_VALUE  = 32'h0064_7069
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              vs_i,
   output fmt_ctrl_t         act_o,
   output logic              start_o
);

   localparam int PAD_W = DATA_W - CTRL_W;

   if (DATA_W < CTRL_W) begin : g_bad_data_w
      $error("rgb_fmt_regs: DATA_W too small for the control word");
   end
   if (CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("rgb_fmt_regs: CTRL_ADDR outside the address space");
   end

   fmt_ctrl_t shadow_q;
   fmt_ctrl_t act_q;
   logic      vs_q;
   logic      en_q;
   logic      wr_ctrl;
   logic      vs_rise;
   fmt_ctrl_t wr_val;

   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign vs_rise = vs_i && !vs_q;
   assign wr_val  = fmt_ctrl_t'(bus_wdata[CTRL_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         act_q    <= '0;
         vs_q     <= 1'b0;
         en_q     <= 1'b0;
      end else begin
         vs_q <= vs_i;
         en_q <= act_q.en;
         if (wr_ctrl) begin
            shadow_q <= wr_val;
         end
         if (!act_q.en) begin
            if (wr_ctrl) begin
               act_q <= wr_val;
            end
         end else if (vs_rise) begin
            act_q <= wr_ctrl ? wr_val : shadow_q;
         end
      end
   end

   always_comb begin
      if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
         bus_rdata = {{PAD_W{1'b0}}, shadow_q};
      end else begin
         bus_rdata = DATA_W'(ID_VALUE);
      end
   end

   assign act_o   = act_q;
   assign start_o = act_q.en && !en_q;

endmodule

// File: rtl/rgb_fmt_pack.sv
module rgb_fmt_pack
   import rgb_fmt_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic [3*CW-1:0] pix_i,
   input  logic [1:0]      order_i,
   input  logic [2:0]      pack_i,
   output logic [3*CW-1:0] data_o
);

   localparam int DW = 3 * CW;

   if (CW < 6) begin : g_bad_cw
      $error("rgb_fmt_pack: CW must be at least 6");
   end

   logic [CW-1:0] ch_r, ch_g, ch_b;
   logic [CW-1:0] sl_a, sl_b, sl_c;
   logic [4:0]    a5, b5, c5;
   logic [5:0]    a6, b6, c6;

   assign ch_r = pix_i[3*CW-1 -: CW];
   assign ch_g = pix_i[2*CW-1 -: CW];
   assign ch_b = pix_i[CW-1 -: CW];

   always_comb begin
      case (ord_e'(order_i))
         ORD_RGB: {sl_a, sl_b, sl_c} = {ch_r, ch_g, ch_b};
         ORD_BGR: {sl_a, sl_b, sl_c} = {ch_b, ch_g, ch_r};
         ORD_GRB: {sl_a, sl_b, sl_c} = {ch_g, ch_r, ch_b};
         default: {sl_a, sl_b, sl_c} = {ch_b, ch_r, ch_g};
      endcase
   end

   assign a5 = sl_a[CW-1 -: 5];
   assign b5 = sl_b[CW-1 -: 5];
   assign c5 = sl_c[CW-1 -: 5];
   assign a6 = sl_a[CW-1 -: 6];
   assign b6 = sl_b[CW-1 -: 6];
   assign c6 = sl_c[CW-1 -: 6];

   always_comb begin
      case (pack_e'(pack_i))
         PK_565_LO:   data_o = DW'({a5, b6, c5});
         PK_565_LANE: data_o = {{(CW-5){1'b0}}, a5,
                                {(CW-6){1'b0}}, b6,
                                {(CW-5){1'b0}}, c5};
         PK_565_MID:  data_o = {{(CW-6){1'b0}}, a5, 1'b0,
                                {(CW-6){1'b0}}, b6,
                                {(CW-6){1'b0}}, c5, 1'b0};
         PK_666_LO:   data_o = DW'({a6, b6, c6});
         PK_666_LANE: data_o = {{(CW-6){1'b0}}, a6,
                                {(CW-6){1'b0}}, b6,
                                {(CW-6){1'b0}}, c6};
         PK_888:      data_o = {sl_a, sl_b, sl_c};
         default:     data_o = '0;
      endcase
   end

endmodule

// File: rtl/rgb_fmt_launch.sv
module rgb_fmt_launch #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         idle_i,
   input  logic [W-1:0] idle_val_i,
   input  logic [W-1:0] d_i,
   input  logic         neg_sel_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("rgb_fmt_launch: W must be positive");
   end

   logic [W-1:0] rise_q;
   logic [W-1:0] fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q <= '0;
      end else begin
         rise_q <= idle_i ? idle_val_i : d_i;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_q <= '0;
      end else begin
         fall_q <= rise_q;
      end
   end

   assign q_o = neg_sel_i ? fall_q : rise_q;

endmodule

// File: rtl/rgb_par_fmt.sv
module rgb_par_fmt
   import rgb_fmt_pkg::*;
#(
   parameter int          CW        = 8,
   parameter int          ADDR_W    = 4,
   parameter int          CTRL_ADDR = 0,
   parameter logic [31:0] ID_VALUE  = 32'h0064_7069
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [3*CW-1:0]   pix_i,
   input  logic              hs_i,
   input  logic              vs_i,
   input  logic              de_i,
   output logic              out_pclk,
   output logic              out_hs,
   output logic              out_vs,
   output logic              out_de,
   output logic [3*CW-1:0]   out_data
);

   localparam int DW = 3 * CW;

   fmt_ctrl_t        act;
   logic             start;
   logic             idle;
   logic [DW-1:0]    packed_px;
   logic [NSIG-1:0]  sig_raw, sig_inv, sig_dis, sig_neg, sig_pin;

   rgb_fmt_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (32),
      .CTRL_ADDR(CTRL_ADDR),
      .ID_VALUE (ID_VALUE)
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .vs_i     (vs_i),
      .act_o    (act),
      .start_o  (start)
   );

   rgb_fmt_pack #(.CW(CW)) pack_i (
      .pix_i  (pix_i),
      .order_i(act.order),
      .pack_i (act.pack),
      .data_o (packed_px)
   );

   assign idle = !act.en || start;

   assign sig_raw[SIG_HS] = hs_i;
   assign sig_raw[SIG_VS] = vs_i;
   assign sig_raw[SIG_DE] = act.csync ? (hs_i || vs_i) : de_i;
   assign sig_inv = {act.inv_de, act.inv_vs, act.inv_hs};
   assign sig_dis = {act.dis_de, act.dis_vs, act.dis_hs};
   assign sig_neg = {act.neg_de, act.neg_vs, act.neg_hs};

   for (genvar s = 0; s < NSIG; s++) begin : g_sig
      logic lvl;
      assign lvl = sig_dis[s] ? sig_inv[s] : (sig_raw[s] ^ sig_inv[s]);
      rgb_fmt_launch #(.W(1)) launch_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .idle_i    (idle),
         .idle_val_i(sig_inv[s]),
         .d_i       (lvl),
         .neg_sel_i (sig_neg[s]),
         .q_o       (sig_pin[s])
      );
   end

   rgb_fmt_launch #(.W(DW)) launch_data_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle_i    (idle),
      .idle_val_i({DW{1'b0}}),
      .d_i       (packed_px),
      .neg_sel_i (act.neg_de),
      .q_o       (out_data)
   );

   assign out_hs   = sig_pin[SIG_HS];
   assign out_vs   = sig_pin[SIG_VS];
   assign out_de   = sig_pin[SIG_DE];
   assign out_pclk = act.en && (clk ^ act.inv_pclk);

endmodule

// File: rtl/rgb_par_fmt_chk.sv
module rgb_par_fmt_chk
   import rgb_fmt_pkg::*;
#(
   parameter int          ADDR_W    = 4,
   parameter int          DW        = 24,
   parameter int          CTRL_ADDR = 0,
   parameter logic [31:0] ID_VALUE  = 32'h0064_7069
) (
   input logic              clk,
   input logic              rst_n,
   input fmt_ctrl_t         act,
   input logic              start,
   input logic              hs_i,
   input logic              vs_i,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [DW-1:0]     out_data,
   input logic              out_hs,
   input logic              out_de
);

   // R2
   id_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != ADDR_W'(CTRL_ADDR)) |-> (bus_rdata == ID_VALUE));

   // R8
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!act.en) |-> (out_data == '0) && (out_de == $past(act.inv_de)));

   // R8
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start) |-> (out_data == '0));

   // R7
   hs_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(act.dis_hs) |-> (out_hs == $past(act.inv_hs)));

   // R9
   csync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act.en && !start && act.csync && !act.dis_de) && !act.neg_de)
      |-> (out_de == ($past(hs_i || vs_i) ^ $past(act.inv_de))));

   // R10
   stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act != $past(act)) |-> ($past(!act.en) || ($past(vs_i) && !$past(vs_i, 2))));

endmodule

bind rgb_par_fmt rgb_par_fmt_chk #(
   .ADDR_W   (ADDR_W),
   .DW       (3 * CW),
   .CTRL_ADDR(CTRL_ADDR),
   .ID_VALUE (ID_VALUE)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .act      (act),
   .start    (start),
   .hs_i     (hs_i),
   .vs_i     (vs_i),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .out_data (out_data),
   .out_hs   (out_hs),
   .out_de   (out_de)
);

// File: tb/rgb_par_fmt_tb_top.sv
module rgb_par_fmt_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [23:0] pix_i = '0;
   logic        hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
   logic        out_pclk, out_hs, out_vs, out_de;
   logic [23:0] out_data;

   int errs = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   rgb_par_fmt dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_i(pix_i),
      .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i), .out_pclk(out_pclk),
      .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de), .out_data(out_data)
   );

   typedef struct packed {
      logic [23:0] d;
      logic        hs;
      logic        vs;
      logic        de;
   } pins_t;

   logic [16:0] mcfg = '0;
   pins_t       prev = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic pins_t model(input logic [16:0] c, input logic [23:0] p,
                                   input logic h, input logic v, input logic e);
      logic [7:0] r, g, b, a0, a1, a2;
      pins_t o;
      r = p[23:16]; g = p[15:8]; b = p[7:0];
      case (c[15:14])
         2'd0:    {a0, a1, a2} = {r, g, b};
         2'd1:    {a0, a1, a2} = {b, g, r};
         2'd2:    {a0, a1, a2} = {g, r, b};
         default: {a0, a1, a2} = {b, r, g};
      endcase
      case (c[13:11])
         3'd1:    o.d = {8'h00, a0[7:3], a1[7:2], a2[7:3]};
         3'd2:    o.d = {3'b0, a0[7:3], 2'b0, a1[7:2], 3'b0, a2[7:3]};
         3'd3:    o.d = {2'b0, a0[7:3], 3'b0, a1[7:2], 2'b0, a2[7:3], 1'b0};
         3'd4:    o.d = {6'b0, a0[7:2], a1[7:2], a2[7:2]};
         3'd5:    o.d = {2'b0, a0[7:2], 2'b0, a1[7:2], 2'b0, a2[7:2]};
         3'd6:    o.d = {a0, a1, a2};
         default: o.d = 24'h0;
      endcase
      if (!c[0]) begin
         o.d = 24'h0; o.hs = c[9]; o.vs = c[8]; o.de = c[7];
      end else begin
         o.hs = c[3] ? c[9] : (h ^ c[9]);
         o.vs = c[2] ? c[8] : (v ^ c[8]);
         o.de = c[1] ? c[7] : ((c[16] ? (h | v) : e) ^ c[7]);
      end
      return o;
   endfunction

   // Called a quarter cycle before a rising edge; returns at the same phase.
   task automatic apply(input logic [23:0] p, input logic h, input logic v,
                        input logic e, input bit early, input string req);
      pins_t n;
      n = model(mcfg, p, h, v, e);
      pix_i = p; hs_i = h; vs_i = v; de_i = e;
      @(posedge clk);
      #1.5;
      if (early) begin
         chk("R5 pclk high phase", out_pclk, mcfg[0] ? !mcfg[10] : 1'b0);
         chk("R6 hs launch", out_hs, mcfg[6] ? prev.hs : n.hs);
         chk("R6 vs launch", out_vs, mcfg[5] ? prev.vs : n.vs);
         chk("R6 de launch", out_de, mcfg[4] ? prev.de : n.de);
         chk("R6 data launch", out_data, mcfg[4] ? prev.d : n.d);
      end
      #2.5;
      chk("R5 pclk low phase", out_pclk, mcfg[0] ? mcfg[10] : 1'b0);
      chk({req, " data"}, out_data, n.d);
      chk({req, " hs"}, out_hs, n.hs);
      chk({req, " vs"}, out_vs, n.vs);
      chk({req, " de"}, out_de, n.de);
      prev = n;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #4;
      bus_we = 1'b0; bus_addr = '0;
   endtask

   task automatic cfg(input logic [31:0] c);
      vs_i = 1'b0; hs_i = 1'b0; de_i = 1'b0; pix_i = '0;
      bus_write(4'd0, c);
      vs_i = 1'b1;
      @(posedge clk); #4;
      vs_i = 1'b0;
      @(posedge clk); #4;
      @(posedge clk); #4;
      mcfg = c[16:0];
      prev = model(mcfg, 24'h0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      #4;
      chk("R1 data", out_data, 24'h0);
      chk("R1 hs", out_hs, 1'b0);
      chk("R1 vs", out_vs, 1'b0);
      chk("R1 de", out_de, 1'b0);
      chk("R1 pclk", out_pclk, 1'b0);
      chk("R1 ctrl read", bus_rdata, 32'h0);
      @(posedge clk); #4;
      rst_n = 1'b1;
      @(posedge clk); #4;

      // R2: identifier at every non-control address
      for (int a = 1; a < 16; a++) begin
         bus_addr = 4'(a);
         @(posedge clk); #4;
         chk("R2 id read", bus_rdata, 32'h0064_7069);
      end
      bus_addr = '0;
      bus_write(4'd0, 32'hFFFF_5554);
      chk("R2 ctrl readback", bus_rdata, 32'h0001_5554);

      // R3/R4: order x packing sweep
      for (int o = 0; o < 4; o++) begin
         for (int k = 0; k < 8; k++) begin
            logic [31:0] c;
            c = {15'b0, 1'b0, 2'(o), 3'(k), 10'b0, 1'b1};
            cfg(c);
            chk("R2 ctrl readback", bus_rdata, c);
            apply(24'hFFFFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R3/R4");
            apply(24'h80_40_01, 1'b0, 1'b0, 1'b1, 1'b1, "R3/R4");
            apply(24'hA5_5A_C3, 1'b1, 1'b0, 1'b1, 1'b1, "R3/R4");
            apply({8'(o * 17 + k), 8'hC3, 8'(k * 29)}, 1'b0, 1'b0, 1'b0, 1'b1, "R3/R4");
         end
      end

      // R5/R6/R7/R9: every combination of the polarity, edge and disable bits
      for (int k = 0; k < 1024; k++) begin
         logic [31:0] c;
         c = {15'b0, 1'(k ^ (k >> 3)), 2'(k), 3'd6, 10'(k), 1'b1};
         cfg(c);
         apply(24'h0F1E2D ^ 24'(k), 1'b1, 1'b0, 1'b1, 1'b1, "R5/R7/R9");
         apply(24'hF0E1D2 ^ 24'(k), 1'b0, 1'b1, 1'b0, 1'b1, "R5/R7/R9");
         apply(24'h3C3C3C ^ 24'(k), 1'b1, 1'b1, 1'b1, 1'b1, "R5/R7/R9");
         apply(24'hC3C3C3 ^ 24'(k), 1'b0, 1'b0, 1'b0, 1'b1, "R5/R7/R9");
      end

      // R8: disabled block holds idle levels
      cfg(32'h0000_0780);
      apply(24'hFFFFFF, 1'b1, 1'b0, 1'b1, 1'b1, "R8 disabled");
      apply(24'h123456, 1'b0, 1'b0, 1'b0, 1'b1, "R8 disabled");
      apply(24'hABCDEF, 1'b1, 1'b0, 1'b0, 1'b1, "R8 disabled");

      // R8/R10: enable applies at once, first cycle stays idle
      cfg(32'h0000_0000);
      pix_i = 24'hFFFFFF; hs_i = 1'b0; vs_i = 1'b0; de_i = 1'b1;
      bus_write(4'd0, 32'h0000_3001);
      @(posedge clk); #4;
      chk("R8 start data", out_data, 24'h0);
      chk("R8 start de", out_de, 1'b0);
      mcfg = 17'h03001;
      prev = '0;
      apply(24'h13579B, 1'b0, 1'b0, 1'b1, 1'b1, "R8 after start");
      apply(24'h2468AC, 1'b0, 1'b0, 1'b1, 1'b1, "R8 after start");

      // R10: enabled write waits for a vsync rising edge
      bus_write(4'd0, 32'h0000_2001);
      chk("R10 shadow readback", bus_rdata, 32'h0000_2001);
      apply(24'h8899AA, 1'b0, 1'b0, 1'b1, 1'b1, "R10 before vsync");
      apply(24'h8899AA, 1'b0, 1'b0, 1'b1, 1'b1, "R10 before vsync");
      apply(24'h8899AA, 1'b0, 1'b1, 1'b1, 1'b1, "R10 vsync edge");
      mcfg = 17'h02001;
      apply(24'h8899AA, 1'b0, 1'b0, 1'b1, 1'b1, "R10 after vsync");
      apply(24'h556677, 1'b0, 1'b0, 1'b1, 1'b1, "R10 after vsync");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule